// File: doc/BRIEF.md
# Error Collection and Reaction Controller

This block gathers error flags from a set of independent hardware monitors, holds each one in a sticky status bit, and turns each bit into reactions. Each source has its own enable for three reactions: an external error-out pin, an interrupt line and a reset request. Several reactions may be enabled for the same source.

The external pin can be held back by a programmable delay. During that delay the interrupt is already active, so software can prepare the system for shutdown before outside components see the failure. Clearing the pin-enabled status bits during the delay cancels the pending pin assertion. A reset request is not held back by the delay. When a reset fires, any running delay ends and the pin asserts together with the reset pulse.

Software clears a status bit by writing one to the matching clear bit. The configuration inputs are expected to be driven from registers elsewhere in the chip.

Top module: `err_reaction_ctrl`

## Requirements
- R1: A source whose `err_i` bit is high at a clock edge sets its `status_o` bit at that edge. The bit stays set when the input falls.
- R2: A status bit falls only at an edge where its `clr_i` bit is one, and only that bit is affected. An error and a clear on the same bit at the same edge leave the bit set.
- R3: `irq_o` is high in the cycle after a latched status bit whose `irq_en_i` bit is set. It stays high until no such bit remains.
- R4: The pin rises in the cycle after the latch edge when `dly_en_i` is 0, or when `dly_val_i` is 0.
- R5: When `dly_en_i` is 1 and `dly_val_i` is D > 0, the pin rises D cycles later than it would under R4. `irq_o` is active during that window.
- R6: `err_pin_o` stays high until every status bit whose `pin_en_i` bit is set has been cleared. It falls in the cycle after the last such clear. Clearing those bits during the delay cancels the pending assertion.
- R7: A newly latched status bit whose `rst_en_i` bit is set produces a `rst_req_o` pulse exactly one cycle wide. The pulse comes in the cycle after the latch edge.
- R8: A reset request cuts a running delay short. The pin rises in the same cycle as the reset pulse.
- R9: Sources that fire in the same cycle are combined by OR. A pin-enabled source that fires while a delay is running neither restarts nor lengthens that delay.
- R10: A latched source with a reaction enable at 0 has no effect on that reaction's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_i | input | N_SRC | Error flags from the monitors, one bit per source |
| clr_i | input | N_SRC | Write-one-to-clear strobe for each status bit |
| pin_en_i | input | N_SRC | Per-source enable for the error-out pin |
| irq_en_i | input | N_SRC | Per-source enable for the interrupt |
| rst_en_i | input | N_SRC | Per-source enable for the reset request |
| dly_en_i | input | 1 | Enables the pin delay |
| dly_val_i | input | DLY_W | Pin delay in cycles |
| status_o | output | N_SRC | Sticky error status |
| err_pin_o | output | 1 | External error-out pin, active high |
| irq_o | output | 1 | Interrupt, level |
| rst_req_o | output | 1 | Reset request, one-cycle pulse |

## Verification
The bench builds the block with N_SRC = 6 and DLY_W = 4. With six sources, one vector row can mix pin-only, interrupt-only, reset-only and unrouted sources. The 4-bit delay makes the largest delay of 15 cycles cheap to reach, so the bench can time the pin edge exactly at that boundary as well as at zero. The same short widths keep the cancel window, the reset cut-short case and a late source during a running delay within a few dozen cycles each.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [1:0] {
    PIN_IDLE = 2'd0,
    PIN_WAIT = 2'd1,
    PIN_ON   = 2'd2
  } pin_state_e;
endpackage

// File: rtl/erc_status_bank.sv
module erc_status_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] err_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] status_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    logic sts_q;
    // a new error wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sts_q <= 1'b0;
      else if (err_i[g])  sts_q <= 1'b1;
      else if (clr_i[g])  sts_q <= 1'b0;
    end
    assign status_o[g] = sts_q;
  end
endmodule

// File: rtl/erc_reset_pulse.sv
module erc_reset_pulse #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] status_i,
  input  logic [N_SRC-1:0] rst_en_i,
  output logic             rst_new_o,
  output logic             rst_req_o
);
  logic [N_SRC-1:0] armed;
  logic [N_SRC-1:0] seen_q;
  logic             req_q;

  assign armed     = status_i & rst_en_i;
  assign rst_new_o = |(armed & ~seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      req_q  <= 1'b0;
    end else begin
      seen_q <= armed;
      req_q  <= rst_new_o;
    end
  end

  assign rst_req_o = req_q;
endmodule

// File: rtl/erc_pin_timer.sv
module erc_pin_timer
  import erc_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pend_i,
  input  logic             rst_new_i,
  input  logic             dly_en_i,
  input  logic [DLY_W-1:0] dly_val_i,
  output logic             pin_o
);
  pin_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             no_delay;

  assign no_delay = !dly_en_i || (dly_val_i == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PIN_IDLE: begin
        if (pend_i) begin
          if (no_delay || rst_new_i) begin
            state_d = PIN_ON;
          end else begin
            state_d = PIN_WAIT;
            cnt_d   = dly_val_i - 1'b1;
          end
        end
      end
      PIN_WAIT: begin
        if (!pend_i)                      state_d = PIN_IDLE;
        else if (rst_new_i || cnt_q == '0) state_d = PIN_ON;
        else                              cnt_d   = cnt_q - 1'b1;
      end
      PIN_ON: begin
        if (!pend_i) state_d = PIN_IDLE;
      end
      default: state_d = PIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PIN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pin_o = (state_q == PIN_ON);
endmodule

// File: rtl/err_reaction_ctrl.sv
module err_reaction_ctrl #(
  parameter int N_SRC = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] err_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] pin_en_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic [N_SRC-1:0] rst_en_i,
  input  logic             dly_en_i,
  input  logic [DLY_W-1:0] dly_val_i,
  output logic [N_SRC-1:0] status_o,
  output logic             err_pin_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic [N_SRC-1:0] status;
  logic             rst_new;
  logic             irq_q;

  erc_status_bank #(.N_SRC(N_SRC)) i_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_i),
    .clr_i    (clr_i),
    .status_o (status)
  );

  erc_reset_pulse #(.N_SRC(N_SRC)) i_rstp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .status_i  (status),
    .rst_en_i  (rst_en_i),
    .rst_new_o (rst_new),
    .rst_req_o (rst_req_o)
  );

  erc_pin_timer #(.DLY_W(DLY_W)) i_pin (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (|(status & pin_en_i)),
    .rst_new_i (rst_new),
    .dly_en_i  (dly_en_i),
    .dly_val_i (dly_val_i),
    .pin_o     (err_pin_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status & irq_en_i);
  end

  assign irq_o    = irq_q;
  assign status_o = status;
endmodule

// File: rtl/erc_checker.sv
module erc_checker #(
  parameter int N_SRC = 8,
  parameter int DLY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] err_i,
  input logic [N_SRC-1:0] clr_i,
  input logic [N_SRC-1:0] pin_en_i,
  input logic [N_SRC-1:0] irq_en_i,
  input logic [N_SRC-1:0] rst_en_i,
  input logic             dly_en_i,
  input logic [DLY_W-1:0] dly_val_i,
  input logic [N_SRC-1:0] status_o,
  input logic             err_pin_o,
  input logic             irq_o,
  input logic             rst_req_o
);
  a_r1_error_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(err_i) & ~status_o) == '0));

  a_r2_clear_only_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));

  a_r3_irq_follows_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |($past(status_o) & $past(irq_en_i)));

  a_r6_pin_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pin_o |-> |($past(status_o) & $past(pin_en_i)));

  a_r7_reset_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> |($past(status_o) & $past(rst_en_i)));
endmodule

bind err_reaction_ctrl erc_checker #(.N_SRC(N_SRC), .DLY_W(DLY_W)) i_erc_checker (.*);

// File: tb/test_err_reaction_ctrl.sv
module test_err_reaction_ctrl;
  localparam int N = 6;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  err = '0, clr = '0, pin_en = '0, irq_en = '0, rst_en = '0;
  logic          dly_en = 1'b0;
  logic [DW-1:0] dly_val = '0;
  logic [N-1:0]  status;
  logic          pin, irq, rreq;
  int            n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  err_reaction_ctrl #(.N_SRC(N), .DLY_W(DW)) i_err_reaction_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .clr_i(clr),
    .pin_en_i(pin_en), .irq_en_i(irq_en), .rst_en_i(rst_en),
    .dly_en_i(dly_en), .dly_val_i(dly_val),
    .status_o(status), .err_pin_o(pin), .irq_o(irq), .rst_req_o(rreq)
  );

  // {err, pin_en, irq_en, exp_pin, exp_irq}
  localparam logic [3*N+1:0] VEC [6] = '{
    {6'b000001, 6'b000001, 6'b000000, 1'b1, 1'b0},
    {6'b000010, 6'b000001, 6'b000010, 1'b0, 1'b1},
    {6'b001100, 6'b001000, 6'b000100, 1'b1, 1'b1},
    {6'b110000, 6'b000000, 6'b000000, 1'b0, 1'b0},
    {6'b111111, 6'b101010, 6'b010101, 1'b1, 1'b1},
    {6'b000000, 6'b111111, 6'b111111, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); clr = '1;
    @(negedge clk); clr = '0;
    @(negedge clk);
  endtask

  // pulses err for one cycle, returns the negedge index at which the pin is first high
  task automatic rise_idx(input logic [N-1:0] e, output int idx);
    idx = 0;
    @(negedge clk); err = e;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) err = '0;
      if (pin) begin idx = k; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idx;
    logic seen;
    repeat (3) @(negedge clk);
    chk("reset status", status, 0);
    chk("reset outputs", {pin, irq, rreq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("idle after reset", {status, pin, irq, rreq}, 0);

    // vector table, delay off: R1 R3 R4 R10
    foreach (VEC[i]) begin
      pin_en = VEC[i][2*N+1 -: N];
      irq_en = VEC[i][N+1 -: N];
      @(negedge clk); err = VEC[i][3*N+1 -: N];
      @(negedge clk); err = '0;
      @(negedge clk);
      chk($sformatf("R1 row%0d status", i), status, VEC[i][3*N+1 -: N]);
      chk($sformatf("R4/R10 row%0d pin", i), pin, VEC[i][1]);
      chk($sformatf("R3/R10 row%0d irq", i), irq, VEC[i][0]);
      chk($sformatf("R10 row%0d rst", i), rreq, 0);
      repeat (3) @(negedge clk);
      chk($sformatf("R1 row%0d sticky", i), status, VEC[i][3*N+1 -: N]);
      clear_all();
      chk($sformatf("R6 row%0d cleared", i), {status, pin, irq}, 0);
    end

    // R2 partial clear and set-wins
    pin_en = '0; irq_en = '0;
    @(negedge clk); err = 6'b000101;
    @(negedge clk); err = '0; clr = 6'b000001;
    @(negedge clk); clr = '0;
    chk("R2 only strobed bit clears", status, 6'b000100);
    err = 6'b000100; clr = 6'b000100;
    @(negedge clk); err = '0; clr = '0;
    chk("R2 set wins over clear", status, 6'b000100);
    clear_all();

    // R4 zero delay with delay enabled, and nonzero value with delay disabled
    pin_en = 6'b000001; irq_en = 6'b000001;
    dly_en = 1'b1; dly_val = 0;
    rise_idx(6'b000001, idx);
    chk("R4 zero delay", idx, 2);
    clear_all();
    dly_en = 1'b0; dly_val = 7;
    rise_idx(6'b000001, idx);
    chk("R4 delay disabled", idx, 2);
    clear_all();

    // R5 delays, including the maximum
    dly_en = 1'b1; dly_val = 3;
    rise_idx(6'b000001, idx);
    chk("R5 delay 3", idx, 5);
    clear_all();
    dly_val = 15;
    rise_idx(6'b000001, idx);
    chk("R5 delay 15", idx, 17);
    clear_all();

    // R5 irq active while pin held back
    dly_val = 8;
    @(negedge clk); err = 6'b000001;
    @(negedge clk); err = '0;
    @(negedge clk);
    chk("R5 irq during delay", {irq, pin}, 2'b10);
    clear_all();

    // R6 cancel during delay
    dly_val = 10; seen = 1'b0;
    @(negedge clk); err = 6'b000001;
    @(negedge clk); err = '0;
    @(negedge clk); @(negedge clk); clr = 6'b000001;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); clr = '0;
      if (pin) seen = 1'b1;
    end
    chk("R6 cancel in delay", seen, 0);

    // R9 two sources at once, then a late source during delay
    pin_en = 6'b000111; dly_val = 4;
    rise_idx(6'b000011, idx);
    chk("R9 same-cycle sources", idx, 6);
    clear_all();
    idx = 0;
    @(negedge clk); err = 6'b000001;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      err = (k == 2) ? 6'b000100 : '0;
      if (pin && idx == 0) idx = k;
    end
    chk("R9 late source keeps delay", idx, 6);

    // R6 pin holds until every pin-enabled bit cleared
    @(negedge clk); clr = 6'b000001;
    @(negedge clk); clr = '0;
    @(negedge clk);
    chk("R6 pin holds with one bit left", pin, 1);
    clr = 6'b000100;
    @(negedge clk); clr = '0;
    @(negedge clk);
    chk("R6 pin falls after last clear", pin, 0);
    clear_all();

    // R7 R8 reset pulse cuts the delay
    pin_en = 6'b000001; rst_en = 6'b000010; dly_val = 10;
    @(negedge clk); err = 6'b000001;
    @(negedge clk); err = '0;
    @(negedge clk); err = 6'b000010;
    @(negedge clk); err = '0;
    chk("R7 no pulse at latch edge", {rreq, pin}, 0);
    @(negedge clk);
    chk("R7 R8 pulse with pin", {rreq, pin}, 2'b11);
    @(negedge clk);
    chk("R7 one-cycle pulse", {rreq, pin}, 2'b01);
    clear_all();
    chk("R6 all clear at end", {status, pin, irq, rreq}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule